// File: doc/BRIEF.md
# Branch Decode and Condition Evaluator

This block looks at one 32-bit instruction word and decides, within the same cycle, whether the word is a PC-relative branch and whether that branch goes. It recognises three kinds of branch. The first compares two general-purpose register values for equality. The second tests the sign of one register and always records a return link. The third tests one bit of a condition vector that belongs to the floating-point unit or to the second coprocessor.

The fetch or issue stage places the block beside the register read ports. The stage feeds the block the raw word, both operand values and the two 8-bit condition vectors. The block returns a branch flag, a taken flag, a flag that asks for the delay-slot instruction to be squashed when the branch falls through, a link-write request with its destination index, and a byte displacement that is ready to add to the delay-slot address. The register file, the target adder and the logic that writes the condition vectors belong to other blocks.

Top module: `branch_eval`

## Requirements
- R1: Only four encodings count as branches: opcode (bits 31:26) 000100, opcode 000001 with bits 20:16 equal to 10001, and opcodes 010001 or 010010 with bits 25:21 equal to 01000. Every other word drives isBranch, taken, likely, linkEn, linkIdx and byteOffset to zero.
- R2: For opcode 000100, taken is 1 exactly when rsVal equals rtVal. When both operands are zero the branch is therefore always taken.
- R3: For the sign-link form (opcode 000001, bits 20:16 = 10001), taken is 1 exactly when bit 31 of rsVal is 0.
- R4: For a coprocessor condition branch, bits 20:18 select one bit of the condition vector. Opcode 010001 reads fpCond and opcode 010010 reads cp2Cond. The branch is taken when the selected bit equals bit 16 of the word, so bit 16 = 1 branches on a set bit and bit 16 = 0 branches on a clear bit.
- R5: likely equals bit 17 of the word for a coprocessor condition branch. It is 0 for every other word.
- R6: For any branch, byteOffset equals bits 15:0 shifted left by two and sign-extended to 32 bits, so bits 1:0 are 0 and bits 31:17 copy bit 15.
- R7: linkEn is 1 for the sign-link form whether or not that branch is taken, and linkIdx is then 31. For all other words linkEn is 0 and linkIdx is 0.
- R8: Near-miss words are not branches: opcode 000001 with any other value in bits 20:16, and opcode 010001 or 010010 with any other value in bits 25:21.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instrWord | input | 32 | Instruction word under decode |
| rsVal | input | 32 | Value of the register named by bits 25:21 |
| rtVal | input | 32 | Value of the register named by bits 20:16 |
| fpCond | input | 8 | Floating-point condition bits |
| cp2Cond | input | 8 | Second-coprocessor condition bits |
| isBranch | output | 1 | Word is one of the recognised branch forms |
| taken | output | 1 | Branch condition holds |
| likely | output | 1 | Squash the delay slot if the branch is not taken |
| linkEn | output | 1 | Write the return address |
| linkIdx | output | 5 | Destination register for the link write |
| byteOffset | output | 32 | Sign-extended byte displacement |

## Verification
The block holds no state, so any fault shows at the ports in the same evaluation as the input that exposes it. A decode slip shows up in two ways: a flag is raised on a non-branch word, or isBranch drops on a near-miss encoding. A wrong condition select shows up as taken following the wrong vector bit, for example the wrong cc index or fpCond used where cp2Cond was meant. A fault in the displacement path shows up as a byteOffset whose upper bits fail to copy bit 15. Each random word is checked against every output, so a single word is enough to expose any such fault.

// File: rtl/brdec_pkg.sv
package brdec_pkg;
  localparam logic [5:0] OPC_EQ    = 6'b000100;
  localparam logic [5:0] OPC_REGIM = 6'b000001;
  localparam logic [5:0] OPC_COP1  = 6'b010001;
  localparam logic [5:0] OPC_COP2  = 6'b010010;
  localparam logic [4:0] RT_SIGNLINK = 5'b10001;
  localparam logic [4:0] RS_CONDBR   = 5'b01000;

  // Strobes sent from the decoder to the evaluating datapath
  typedef struct packed {
    logic       eqForm;
    logic       signLink;
    logic       copForm;
    logic       copSel;      // 0: floating-point vector, 1: coprocessor-2 vector
    logic       nullifyBit;
    logic       trueBit;
    logic [2:0] ccIdx;
  } brStrobe_t;
endpackage

// File: rtl/brdec_ctrl.sv
module brdec_ctrl
  import brdec_pkg::*;
(
  input  logic [15:0] instrHi,   // instruction bits 31:16
  output brStrobe_t   strobe
);
  logic [5:0] opc;
  logic [4:0] rsField;
  logic [4:0] rtField;
  logic       isCopOpc;

  assign opc     = instrHi[15:10];
  assign rsField = instrHi[9:5];
  assign rtField = instrHi[4:0];
  assign isCopOpc = (opc == OPC_COP1) || (opc == OPC_COP2);

  always_comb begin
    strobe            = '0;
    strobe.eqForm     = (opc == OPC_EQ);
    strobe.signLink   = (opc == OPC_REGIM) && (rtField == RT_SIGNLINK);
    strobe.copForm    = isCopOpc && (rsField == RS_CONDBR);
    strobe.copSel     = (opc == OPC_COP2);
    strobe.nullifyBit = instrHi[1];
    strobe.trueBit    = instrHi[0];
    strobe.ccIdx      = instrHi[4:2];
  end
endmodule

// File: rtl/brdec_dpath.sv
module brdec_dpath
  import brdec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CC_N     = 8,
  parameter int COP_N    = 2,
  parameter int LINK_REG = 31
) (
  input  brStrobe_t                     strobe,
  input  logic [DATA_W-1:0]             rsVal,
  input  logic [DATA_W-1:0]             rtVal,
  input  logic [COP_N-1:0][CC_N-1:0]    condVec,
  input  logic [15:0]                   imm,
  output logic                          isBranch,
  output logic                          taken,
  output logic                          likely,
  output logic                          linkEn,
  output logic [4:0]                    linkIdx,
  output logic [DATA_W-1:0]             byteOffset
);
  localparam int EXT_W = DATA_W - 18;

  logic [COP_N-1:0] selBit;
  logic eqHit;
  logic signHit;
  logic copHit;
  logic [DATA_W-1:0] extOff;

  // One condition-bit selector per coprocessor vector
  for (genvar u = 0; u < COP_N; u++) begin : g_copSel
    assign selBit[u] = condVec[u][strobe.ccIdx];
  end

  assign eqHit   = (rsVal == rtVal);
  assign signHit = ~rsVal[DATA_W-1];
  assign copHit  = (selBit[strobe.copSel] == strobe.trueBit);
  assign extOff  = {{EXT_W{imm[15]}}, imm, 2'b00};

  always_comb begin
    isBranch   = strobe.eqForm | strobe.signLink | strobe.copForm;
    taken      = (strobe.eqForm & eqHit) | (strobe.signLink & signHit) |
                 (strobe.copForm & copHit);
    likely     = strobe.copForm & strobe.nullifyBit;
    linkEn     = strobe.signLink;
    linkIdx    = strobe.signLink ? 5'(LINK_REG) : 5'd0;
    byteOffset = isBranch ? extOff : '0;
  end
endmodule

// File: rtl/branch_eval.sv
module branch_eval
  import brdec_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CC_N     = 8,
  parameter int LINK_REG = 31
) (
  input  logic [31:0]       instrWord,
  input  logic [DATA_W-1:0] rsVal,
  input  logic [DATA_W-1:0] rtVal,
  input  logic [CC_N-1:0]   fpCond,
  input  logic [CC_N-1:0]   cp2Cond,
  output logic              isBranch,
  output logic              taken,
  output logic              likely,
  output logic              linkEn,
  output logic [4:0]        linkIdx,
  output logic [DATA_W-1:0] byteOffset
);
  localparam int COP_N = 2;

  brStrobe_t strobe;
  logic [COP_N-1:0][CC_N-1:0] condVec;

  assign condVec = {cp2Cond, fpCond};

  brdec_ctrl u_ctrl (
    .instrHi (instrWord[31:16]),
    .strobe  (strobe)
  );

  brdec_dpath #(
    .DATA_W   (DATA_W),
    .CC_N     (CC_N),
    .COP_N    (COP_N),
    .LINK_REG (LINK_REG)
  ) u_dpath (
    .strobe     (strobe),
    .rsVal      (rsVal),
    .rtVal      (rtVal),
    .condVec    (condVec),
    .imm        (instrWord[15:0]),
    .isBranch   (isBranch),
    .taken      (taken),
    .likely     (likely),
    .linkEn     (linkEn),
    .linkIdx    (linkIdx),
    .byteOffset (byteOffset)
  );
endmodule

// File: rtl/brdec_chk.sv
module brdec_chk #(
  parameter int DATA_W = 32
) (
  input logic              offSign,
  input logic              isBranch,
  input logic              taken,
  input logic              likely,
  input logic              linkEn,
  input logic [4:0]        linkIdx,
  input logic [DATA_W-1:0] byteOffset
);
  always_comb begin
    AST_TAKEN_IMPLIES_BRANCH: assert (!taken || isBranch); // R1
    AST_IDLE_OUTPUTS_ZERO: assert (isBranch || (!likely && !linkEn && linkIdx == 5'd0 && byteOffset == '0)); // R1
    AST_LIKELY_IMPLIES_BRANCH: assert (!likely || isBranch); // R5
    AST_OFFSET_WORD_ALIGNED: assert (byteOffset[1:0] == 2'b00); // R6
    AST_OFFSET_SIGN_COPY: assert (!isBranch || byteOffset[DATA_W-1:17] == {(DATA_W-17){offSign}}); // R6
    AST_LINK_TARGET: assert (linkEn ? (linkIdx == 5'd31) : (linkIdx == 5'd0)); // R7
  end
endmodule

bind branch_eval brdec_chk #(.DATA_W(DATA_W)) u_chk (
  .offSign    (instrWord[15]),
  .isBranch   (isBranch),
  .taken      (taken),
  .likely     (likely),
  .linkEn     (linkEn),
  .linkIdx    (linkIdx),
  .byteOffset (byteOffset)
);

// File: tb/branch_eval_tb.sv
module branch_eval_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_RANDOM   = 3000;
  localparam int WATCHDOG   = 100000;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instrWord, rsVal, rtVal;
  logic [7:0]  fpCond, cp2Cond;
  logic        isBranch, taken, likely, linkEn;
  logic [4:0]  linkIdx;
  logic [31:0] byteOffset;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  branch_eval u_dut (
    .instrWord (instrWord), .rsVal (rsVal), .rtVal (rtVal),
    .fpCond (fpCond), .cp2Cond (cp2Cond),
    .isBranch (isBranch), .taken (taken), .likely (likely),
    .linkEn (linkEn), .linkIdx (linkIdx), .byteOffset (byteOffset)
  );

  task automatic check(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual=%h expected=%h instr=%h", tag, what, act, exp, instrWord);
    end
  endtask

  // Reference model written from the requirement text
  task automatic expect_all(output logic eB, output logic eT, output logic eL,
                            output logic eK, output logic [4:0] eI,
                            output logic [31:0] eO, output string tag);
    logic [5:0] op = instrWord[31:26];
    logic [4:0] rsF = instrWord[25:21];
    logic [4:0] rtF = instrWord[20:16];
    logic [7:0] vec;
    eB = 0; eT = 0; eL = 0; eK = 0; eI = 0; eO = 0; tag = "R8";
    if (op == 6'b000100) begin
      eB = 1; eT = (rsVal == rtVal); tag = "R2";
    end else if (op == 6'b000001 && rtF == 5'b10001) begin
      eB = 1; eT = !rsVal[31]; eK = 1; eI = 5'd31; tag = "R3";
    end else if ((op == 6'b010001 || op == 6'b010010) && rsF == 5'b01000) begin
      vec = (op == 6'b010001) ? fpCond : cp2Cond;
      eB = 1; eT = (vec[instrWord[20:18]] == instrWord[16]);
      eL = instrWord[17]; tag = "R4";
    end
    if (eB) eO = {{14{instrWord[15]}}, instrWord[15:0], 2'b00};
  endtask

  task automatic apply_and_check(input logic [31:0] w, input logic [31:0] a,
                                 input logic [31:0] b, input logic [7:0] f,
                                 input logic [7:0] c);
    logic eB, eT, eL, eK;
    logic [4:0] eI;
    logic [31:0] eO;
    string tag;
    @(negedge clk);
    instrWord = w; rsVal = a; rtVal = b; fpCond = f; cp2Cond = c;
    #(CLK_PERIOD/4);
    expect_all(eB, eT, eL, eK, eI, eO, tag);
    check(eB ? tag : "R1", "isBranch", {31'd0, isBranch}, {31'd0, eB});
    check(tag, "taken", {31'd0, taken}, {31'd0, eT});
    check("R5", "likely", {31'd0, likely}, {31'd0, eL});
    check("R7", "linkEn", {31'd0, linkEn}, {31'd0, eK});
    check("R7", "linkIdx", {27'd0, linkIdx}, {27'd0, eI});
    check("R6", "byteOffset", byteOffset, eO);
  endtask

  function automatic logic [31:0] cop_word(input bit unit2, input logic [2:0] cc,
                                           input bit nd, input bit tf, input logic [15:0] off);
    return {unit2 ? 6'b010010 : 6'b010001, 5'b01000, cc, nd, tf, off};
  endfunction

  initial begin
    instrWord = 0; rsVal = 0; rtVal = 0; fpCond = 0; cp2Cond = 0;
    void'($urandom(32'd20240611));
    repeat (3) @(posedge clk);
    rstN = 1'b1;

    // Reset-time state: all-zero word is not a branch (R1)
    apply_and_check(32'h0000_0000, 0, 0, 0, 0);
    // Unconditional equal-compare on zeros (R2)
    apply_and_check({6'b000100, 5'd0, 5'd0, 16'h0004}, 0, 0, 8'h00, 8'h00);
    // Unequal operands, not taken (R2)
    apply_and_check({6'b000100, 5'd3, 5'd4, 16'h0010}, 32'h5, 32'h6, 0, 0);
    // Unconditional call form with rs=0, link written (R3, R7)
    apply_and_check({6'b000001, 5'd0, 5'b10001, 16'h0100}, 0, 0, 0, 0);
    // Negative operand: not taken but link still requested (R3, R7)
    apply_and_check({6'b000001, 5'd9, 5'b10001, 16'h0100}, 32'h8000_0000, 0, 0, 0);
    // Offset extremes (R6)
    apply_and_check({6'b000100, 5'd0, 5'd0, 16'h8000}, 0, 0, 0, 0);
    apply_and_check({6'b000100, 5'd0, 5'd0, 16'h7FFF}, 0, 0, 0, 0);
    // Top cc index, true and false senses, both units (R4, R5)
    apply_and_check(cop_word(0, 3'd7, 1, 1, 16'hFFFF), 0, 0, 8'h80, 8'h00);
    apply_and_check(cop_word(1, 3'd7, 1, 1, 16'hFFFF), 0, 0, 8'h80, 8'h00);
    apply_and_check(cop_word(0, 3'd0, 0, 0, 16'h0001), 0, 0, 8'hFE, 8'h01);
    apply_and_check(cop_word(1, 3'd0, 0, 0, 16'h0001), 0, 0, 8'hFE, 8'h01);
    // Near misses (R8)
    apply_and_check({6'b000001, 5'd0, 5'b10000, 16'h0040}, 0, 0, 0, 0);
    apply_and_check({6'b010001, 5'b01001, 3'd0, 1'b1, 1'b1, 16'h0040}, 0, 0, 8'hFF, 8'hFF);

    for (int i = 0; i < N_RANDOM; i++) begin
      logic [31:0] w, a, b;
      int kind = $urandom % 6;
      w = $urandom; a = $urandom; b = $urandom;
      case (kind)
        0: begin w[31:26] = 6'b000100; if ($urandom % 2) b = a; end
        1: begin w[31:26] = 6'b000001; w[20:16] = 5'b10001; end
        2: w = cop_word(0, 3'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        3: w = cop_word(1, 3'($urandom), 1'($urandom), 1'($urandom), 16'($urandom));
        4: begin
          w[31:26] = 6'b000001;
          if (w[20:16] == 5'b10001) w[16] = 1'b0;
        end
        default: ;
      endcase
      apply_and_check(w, a, b, 8'($urandom), 8'($urandom));
    end

    finished = 1'b1;
    $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  %0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule